// File: doc/BRIEF.md
# Primary Cache Invalidate Driver

This block sits between a processor and a secondary cache controller and owns the
direction of four shared attribute pins: read/write, burst, invalidate and global.
While the processor drives an address, the block leaves these pins as inputs and
records what the processor put on them. When the cache controller needs a line in
the processor's primary cache invalidated, it posts a request with a line address
and a flag that selects the DMA variant. The block then asks for the processor
address bus and waits for the grant. It turns on its output drivers and presents
the address and attributes, with a one-cycle address strobe. It holds the drivers
until the transaction acknowledge comes back and then spends one cycle turning
them off.

The burst pin carries no data-length meaning during these transactions: it is
driven high for a DMA invalidate and low for a plain invalidate. The global and
invalidate pins are driven high, so the processor snoops the address and drops the
line on a hit. A hit on a modified line is copied back by the processor before the
acknowledge arrives. The read/write level is fixed by a parameter. One further
request can wait in a single pending slot while a transaction is in flight.

Top module: `l1_inval_driver`

## Requirements
- R1: After reset, bus_req_o, pin_oe_o, addr_strobe_o, burst_o, inval_o and global_o are 0, and inv_ready_o is 1.
- R2: pin_oe_o is high only from the first cycle of the driven phase through the cycle in which the acknowledge is sampled, and it is never high in a cycle where proc_av_i is high.
- R3: A request sampled at a clock edge raises bus_req_o two edges later, if the block is idle. The driven phase starts at the first edge at which bus_grant_i is 1 and proc_av_i is 0 while the request is held. addr_strobe_o is high for exactly the first cycle of the driven phase.
- R4: While pin_oe_o is high, burst_o equals the request's DMA flag: 1 for DMA invalidate, 0 for plain invalidate.
- R5: While pin_oe_o is high, inval_o and global_o are 1 and rw_o equals the parameter RW_LEVEL.
- R6: While pin_oe_o is high, addr_o equals the address of the request being served.
- R7: The drivers stay on until xfer_ack_i is sampled high after the strobe cycle. At the following edge pin_oe_o and bus_req_o go to 0. The next transaction cannot raise bus_req_o until one further edge has passed.
- R8: A request accepted while a transaction is in flight is held, not dropped. It is served after the current one, with its own address and DMA flag.
- R9: inv_ready_o is 0 while the pending slot is full, and a request posted then has no effect: it never produces a transaction.
- R10: While proc_av_i is high, the block samples rw_i, burst_i, inval_i and global_i onto seen_rw_o, seen_burst_o, seen_inval_o and seen_global_o one edge later. Otherwise these outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_req_i | input | 1 | Invalidate request strobe from the cache controller |
| inv_dma_i | input | 1 | Request is the DMA variant |
| inv_addr_i | input | AW | Line address to invalidate |
| inv_ready_o | output | 1 | Pending slot can accept a request |
| bus_req_o | output | 1 | Request for the processor address bus |
| bus_grant_i | input | 1 | Address bus granted |
| proc_av_i | input | 1 | Processor is driving a valid address |
| xfer_ack_i | input | 1 | Transaction acknowledge |
| pin_oe_o | output | 1 | Output enable for address and attribute pins |
| addr_o | output | AW | Driven address |
| addr_strobe_o | output | 1 | Address strobe, first driven cycle only |
| rw_o | output | 1 | Driven read/write level |
| burst_o | output | 1 | Driven burst level (DMA select) |
| inval_o | output | 1 | Driven invalidate level |
| global_o | output | 1 | Driven global level |
| rw_i | input | 1 | Read/write pin as input |
| burst_i | input | 1 | Burst pin as input |
| inval_i | input | 1 | Invalidate pin as input |
| global_i | input | 1 | Global pin as input |
| seen_rw_o | output | 1 | Last sampled processor read/write |
| seen_burst_o | output | 1 | Last sampled processor burst |
| seen_inval_o | output | 1 | Last sampled processor invalidate |
| seen_global_o | output | 1 | Last sampled processor global |

## Verification
The bench builds the block with AW = 12 and RW_LEVEL = 0. The narrow address keeps
the distinct test addresses easy to read. The low read/write level shows that the
driven value follows the parameter rather than a hard-wired 1. That choice also
separates a driven rw_o from the reset value only through the enable, so the
driven phase has to be checked with pin_oe_o as the qualifier. With these values
the bench covers the plain and DMA variants, a grant that arrives while the
processor still holds its address, a request queued in the pending slot behind a
transaction in flight, and a request rejected because the slot is full.

// File: rtl/l1inv_pkg.sv
// Shared types for the primary cache invalidate driver.
package l1inv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_DRIVE   = 3'd2,
        ST_WAIT    = 3'd3,
        ST_RELEASE = 3'd4
    } inv_state_t;

    // Attribute bundle bit positions
    localparam int ATTR_RW    = 3;
    localparam int ATTR_BURST = 2;
    localparam int ATTR_INV   = 1;
    localparam int ATTR_GLB   = 0;
    localparam int ATTR_W     = 4;
endpackage

// File: rtl/l1inv_pending.sv
// One-entry holding register for invalidate requests.
// Assumes the requester posts only while ready is high; posts while full are ignored.
// A load in the same cycle as a take keeps the slot full with the new request.
module l1inv_pending #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          dma,
    input  logic [AW-1:0] addr,
    input  logic          take,
    output logic          valid,
    output logic          ready,
    output logic          q_dma,
    output logic [AW-1:0] q_addr
);
    logic load;

    // Accept only when the slot is empty
    always_comb load = req && !valid;

    // Slot contents and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            q_dma  <= 1'b0;
            q_addr <= '0;
        end else begin
            if (load) begin
                valid  <= 1'b1;
                q_dma  <= dma;
                q_addr <= addr;
            end else if (take) begin
                valid <= 1'b0;
            end
        end
    end

    // Ready reflects an empty slot
    always_comb ready = !valid;
endmodule

// File: rtl/l1inv_seq.sv
// Invalidate transaction sequencer: request, grant, drive, wait for ack, release.
// Assumes the processor never drives an address while it has granted the bus to
// this block. The drive phase still refuses to start while proc_av is high.
module l1inv_seq
    import l1inv_pkg::*;
#(
    parameter int   AW       = 32,
    parameter logic RW_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_valid,
    input  logic              pend_dma,
    input  logic [AW-1:0]     pend_addr,
    input  logic              grant,
    input  logic              proc_av,
    input  logic              ack,
    output logic              take,
    output logic              bus_req,
    output logic              oe,
    output logic              strobe,
    output logic [ATTR_W-1:0] attr,
    output logic [AW-1:0]     addr
);
    inv_state_t state, state_nx;
    logic       act_dma;

    // Next-state selection
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (pend_valid) state_nx = ST_REQ;
            ST_REQ:     if (grant && !proc_av) state_nx = ST_DRIVE;
            ST_DRIVE:   state_nx = ST_WAIT;
            ST_WAIT:    if (ack) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Pull the pending request when leaving idle
    always_comb take = (state == ST_IDLE) && pend_valid;

    // State, captured request and driven attribute bundle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            act_dma <= 1'b0;
            addr    <= '0;
            attr    <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                act_dma <= pend_dma;
                addr    <= pend_addr;
            end
            if (state == ST_REQ && state_nx == ST_DRIVE) begin
                attr[ATTR_RW]    <= RW_LEVEL;
                attr[ATTR_BURST] <= act_dma;
                attr[ATTR_INV]   <= 1'b1;
                attr[ATTR_GLB]   <= 1'b1;
            end else if (state_nx == ST_RELEASE) begin
                attr <= '0;
            end
        end
    end

    // Pin controls decoded from state
    always_comb begin
        bus_req = (state == ST_REQ) || (state == ST_DRIVE) || (state == ST_WAIT);
        oe      = (state == ST_DRIVE) || (state == ST_WAIT);
        strobe  = (state == ST_DRIVE);
    end
endmodule

// File: rtl/l1inv_sampler.sv
// Captures the processor's attribute pins while it drives a valid address.
// Holds the last captured value otherwise.
module l1inv_sampler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] pins,
    output logic [W-1:0] seen
);
    // Capture register
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else if (en) seen <= pins;
    end
endmodule

// File: rtl/l1_inval_driver.sv
// Top of the primary cache invalidate driver. Connects the pending slot, the
// sequencer and the input sampler. Pins are split into input, output and a shared
// output enable for the pad ring.
module l1_inval_driver
    import l1inv_pkg::*;
#(
    parameter int   AW       = 32,
    parameter logic RW_LEVEL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inv_req_i,
    input  logic          inv_dma_i,
    input  logic [AW-1:0] inv_addr_i,
    output logic          inv_ready_o,
    output logic          bus_req_o,
    input  logic          bus_grant_i,
    input  logic          proc_av_i,
    input  logic          xfer_ack_i,
    output logic          pin_oe_o,
    output logic [AW-1:0] addr_o,
    output logic          addr_strobe_o,
    output logic          rw_o,
    output logic          burst_o,
    output logic          inval_o,
    output logic          global_o,
    input  logic          rw_i,
    input  logic          burst_i,
    input  logic          inval_i,
    input  logic          global_i,
    output logic          seen_rw_o,
    output logic          seen_burst_o,
    output logic          seen_inval_o,
    output logic          seen_global_o
);
    logic              p_valid, p_dma, take;
    logic [AW-1:0]     p_addr;
    logic [ATTR_W-1:0] attr, seen;

    l1inv_pending #(.AW(AW)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(inv_req_i), .dma(inv_dma_i),
        .addr(inv_addr_i), .take(take), .valid(p_valid), .ready(inv_ready_o),
        .q_dma(p_dma), .q_addr(p_addr)
    );

    l1inv_seq #(.AW(AW), .RW_LEVEL(RW_LEVEL)) u_seq (
        .clk(clk), .rst_n(rst_n), .pend_valid(p_valid), .pend_dma(p_dma),
        .pend_addr(p_addr), .grant(bus_grant_i), .proc_av(proc_av_i),
        .ack(xfer_ack_i), .take(take), .bus_req(bus_req_o), .oe(pin_oe_o),
        .strobe(addr_strobe_o), .attr(attr), .addr(addr_o)
    );

    l1inv_sampler #(.W(ATTR_W)) u_samp (
        .clk(clk), .rst_n(rst_n), .en(proc_av_i),
        .pins({rw_i, burst_i, inval_i, global_i}), .seen(seen)
    );

    // Unpack bundles onto pins
    always_comb begin
        rw_o          = attr[ATTR_RW];
        burst_o       = attr[ATTR_BURST];
        inval_o       = attr[ATTR_INV];
        global_o      = attr[ATTR_GLB];
        seen_rw_o     = seen[ATTR_RW];
        seen_burst_o  = seen[ATTR_BURST];
        seen_inval_o  = seen[ATTR_INV];
        seen_global_o = seen[ATTR_GLB];
    end
endmodule

// File: rtl/l1_inval_driver_chk.sv
// Protocol checker for l1_inval_driver, attached by bind.
module l1_inval_driver_chk #(
    parameter logic RW_LEVEL = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic proc_av_i,
    input logic xfer_ack_i,
    input logic bus_req_o,
    input logic pin_oe_o,
    input logic addr_strobe_o,
    input logic rw_o,
    input logic burst_o,
    input logic inval_o,
    input logic global_o
);
    a_r2_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_oe_o && proc_av_i));
    a_r2_oe_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o |-> bus_req_o);
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe_o |=> (!addr_strobe_o && pin_oe_o));
    a_r5_attr_levels: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o |-> (inval_o && global_o && rw_o == RW_LEVEL));
    a_r4_burst_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o && !addr_strobe_o) |-> $stable(burst_o));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o && (addr_strobe_o || !xfer_ack_i)) |=> pin_oe_o);
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o && !addr_strobe_o && xfer_ack_i) |=> (!pin_oe_o && !bus_req_o));
endmodule

bind l1_inval_driver l1_inval_driver_chk #(.RW_LEVEL(RW_LEVEL)) u_chk (
    .clk(clk), .rst_n(rst_n), .proc_av_i(proc_av_i), .xfer_ack_i(xfer_ack_i),
    .bus_req_o(bus_req_o), .pin_oe_o(pin_oe_o), .addr_strobe_o(addr_strobe_o),
    .rw_o(rw_o), .burst_o(burst_o), .inval_o(inval_o), .global_o(global_o)
);

// File: tb/tb_l1_inval_driver.sv
// Directed bench for l1_inval_driver.
module tb_l1_inval_driver;
    localparam int   AW = 12;
    localparam logic RWL = 1'b0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic inv_req = 0, inv_dma = 0, grant = 0, av = 0, ack = 0;
    logic [AW-1:0] inv_addr = '0;
    logic rw_i = 0, burst_i = 0, inval_i = 0, global_i = 0;
    logic ready, breq, oe, strobe, rw_o, burst_o, inval_o, global_o;
    logic s_rw, s_burst, s_inval, s_global;
    logic [AW-1:0] addr_o;
    int checks = 0, fails = 0, strobes = 0;

    always #2 clk = ~clk;

    l1_inval_driver #(.AW(AW), .RW_LEVEL(RWL)) dut (
        .clk(clk), .rst_n(rst_n), .inv_req_i(inv_req), .inv_dma_i(inv_dma),
        .inv_addr_i(inv_addr), .inv_ready_o(ready), .bus_req_o(breq),
        .bus_grant_i(grant), .proc_av_i(av), .xfer_ack_i(ack), .pin_oe_o(oe),
        .addr_o(addr_o), .addr_strobe_o(strobe), .rw_o(rw_o), .burst_o(burst_o),
        .inval_o(inval_o), .global_o(global_o), .rw_i(rw_i), .burst_i(burst_i),
        .inval_i(inval_i), .global_i(global_i), .seen_rw_o(s_rw),
        .seen_burst_o(s_burst), .seen_inval_o(s_inval), .seen_global_o(s_global)
    );

    always @(posedge clk) if (rst_n && strobe) strobes <= strobes + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic post(input logic [AW-1:0] a, input logic d);
        inv_req = 1; inv_addr = a; inv_dma = d;
        step();
        inv_req = 0;
    endtask

    // Wait for bus request, grant, check the driven phase, acknowledge
    task automatic serve(input logic [AW-1:0] a, input logic d, input string tag);
        int n = 0;
        while (!breq && n < 20) begin step(); n++; end
        check(breq && !oe, {tag, " bus_req before drive"}, {breq, oe}, 2);
        grant = 1; step();
        check(oe && strobe, {tag, " R3 drive start"}, {oe, strobe}, 3);
        check(addr_o == a, {tag, " R6 address"}, addr_o, a);
        check(burst_o == d, {tag, " R4 burst"}, burst_o, d);
        check(inval_o && global_o && rw_o == RWL, {tag, " R5 attrs"},
              {rw_o, inval_o, global_o}, {RWL, 2'b11});
        step();
        check(oe && !strobe, {tag, " R7 hold"}, {oe, strobe}, 2);
        step();
        check(oe, {tag, " R7 hold without ack"}, oe, 1);
        ack = 1; step(); ack = 0; grant = 0;
        check(!oe && !breq, {tag, " R7 release"}, {oe, breq}, 0);
    endtask

    task automatic t_reset();
        check(!breq && !oe && !strobe && ready && !burst_o && !inval_o && !global_o,
              "R1 reset", {breq, oe, strobe, ready}, 1);
    endtask

    task automatic t_plain();
        post(12'h3A0, 0);
        check(!ready && !breq, "R9 slot full after post", {ready, breq}, 0);
        step();
        check(breq, "R3 bus_req two edges after request", breq, 1);
        serve(12'h3A0, 0, "plain");
        step();
        check(!breq, "R7 idle gap", breq, 0);
    endtask

    task automatic t_dma();
        post(12'h5C8, 1);
        serve(12'h5C8, 1, "dma");
        step();
    endtask

    task automatic t_grant_blocked();
        post(12'h111, 1);
        step();
        av = 1; rw_i = 1; burst_i = 0; inval_i = 1; global_i = 1; grant = 1;
        step();
        check(!oe, "R2 no drive while proc address valid", oe, 0);
        check({s_rw, s_burst, s_inval, s_global} == 4'b1011, "R10 sample",
              {s_rw, s_burst, s_inval, s_global}, 4'b1011);
        av = 0; rw_i = 0; inval_i = 0; global_i = 0; burst_i = 1;
        step();
        check(oe && addr_o == 12'h111, "R3 drive after proc releases", addr_o, 12'h111);
        check({s_rw, s_burst, s_inval, s_global} == 4'b1011, "R10 hold",
              {s_rw, s_burst, s_inval, s_global}, 4'b1011);
        step();
        ack = 1; step(); ack = 0; grant = 0;
        check(!oe, "R7 release after blocked grant", oe, 0);
        step();
    endtask

    task automatic t_pending();
        int base;
        post(12'h0F0, 0);
        step();
        grant = 1; step();
        check(oe, "R8 first in flight", oe, 1);
        post(12'h0F8, 1);
        check(!ready, "R9 ready low when full", ready, 0);
        base = strobes;
        post(12'h777, 0);
        ack = 1; step(); ack = 0; grant = 0;
        serve(12'h0F8, 1, "R8 queued");
        step(); step(); step(); step();
        check(!breq && ready, "R9 ignored request made no transaction", {breq, ready}, 1);
        check(strobes - base == 1, "R9 strobe count", strobes - base, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                rst_n = 1; step();
                t_reset();
                t_plain();
                t_dma();
                t_grant_blocked();
                t_pending();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule